// File: doc/BRIEF.md
# Device Mailbox Register Interface

This block is the host-visible mailbox register file of a memory-expansion style device. A host reaches it through a single request port that carries an address, a byte count of 1, 2, 4 or 8, write data and a read/write flag. Each request receives a registered response one cycle later. The region has two parts. The low 32 bytes hold a capability word, a control word with a doorbell bit, a 64-bit command word, a 64-bit status word and a background-status word that always reads as zero. The bytes above offset 32 form a byte-addressable payload buffer of `2**PL_LOG2` bytes.

Writes to the register part are filtered by offset and width together. Writes to the payload are stored as given. When a legal write leaves the doorbell bit set while no command is running, an internal responder latches the command word and works for `LATENCY` cycles. It then writes a return code into the status word, clears the doorbell and pulses `cmd_done`. Both the cycle count and the return code (low command half-word plus one) are fixed stand-ins for a real command executor.

Top module: `mbx_regfile`

## Requirements
- R1: An access is legal only if its size is 1, 2, 4 or 8, its address is a multiple of its size, and address plus size is at most 32 + 2**PL_LOG2. Every request gets `rsp_valid` in the next cycle. For an illegal request `rsp_err` is 1 and `rsp_rdata` is 0, and an illegal write changes nothing.
- R2: A legal read returns the addressed bytes little-endian: byte j of `rsp_rdata` is the byte at address+j for j below the size, and the higher bytes are zero. Writes respond with zero data.
- R3: A legal write at offset 32 or above stores all of its bytes in the payload at any legal width.
- R4: The register map is: capability (32 bit) at 0x00, control (32 bit, doorbell is bit 0) at 0x04, command (64 bit) at 0x08, status (64 bit, return code in bits 15:0, upper bits zero) at 0x10, and background status (64 bit) at 0x18, which always reads as zero.
- R5: Below offset 32, a 4-byte write is stored only at 0x00 or 0x04. A 4-byte write at any other offset is ignored.
- R6: Below offset 32, an 8-byte write is stored only at 0x08. An 8-byte write at 0x00, 0x10 or 0x18 is ignored, and so are all 1- and 2-byte writes.
- R7: After reset, the capability word holds PL_LOG2 (11 by default) in bits 4:0, with the interrupt bit 5 and the background bit 6 at zero and all other bits zero. Control, command and status are zero, and `cmd_busy` and `cmd_done` are low.
- R8: A legal write below offset 32 that leaves the doorbell at 1 while idle starts a command. `cmd_busy` is high in the cycle after that write.
- R9: A command started at edge k completes at edge k+LATENCY. At completion, status bits 15:0 become bits 15:0 of the command latched at start plus one (modulo 2**16), the doorbell reads 0, `cmd_done` is high for exactly one cycle, and `cmd_busy` falls.
- R10: While busy, writes to control cannot clear or re-trigger the doorbell. Command-word rewrites do not affect the pending result, and each start yields exactly one `cmd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address within the region |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data, byte 0 in bits 7:0 |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Previous request was illegal |
| cmd_busy | output | 1 | A command is being processed |
| cmd_done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle:
- the doorbell stays set for as long as a command is busy and is clear in the cycle `cmd_done` is high;
- `cmd_done` never lasts two cycles;
- the status word changes only together with `cmd_done`;
- an error response always carries zero data.

Only the bench's scenarios can show:
- the offset-and-width write filter;
- little-endian assembly of partial reads;
- the exact completion cycle;
- the return code taken from the command latched at start rather than one rewritten while busy.

A byte-level reference model checks random mixed-width traffic over the payload and the register part.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Register part of the region; the payload starts right after it.
    localparam int unsigned REG_BYTES = 32;
    localparam int unsigned REG_AW    = $clog2(REG_BYTES);

    localparam int unsigned OFF_CAP  = 0;
    localparam int unsigned OFF_CTRL = 4;
    localparam int unsigned OFF_CMD  = 8;

    localparam int unsigned CAP_IRQ_BIT = 5;
    localparam int unsigned CAP_BG_BIT  = 6;
    localparam int unsigned CTRL_DB_BIT = 0;

    typedef struct packed {
        logic       valid;
        logic       write;
        logic       legal;
        logic       below;
        logic [3:0] size;
    } acc_t;

    function automatic logic size_ok(input logic [3:0] s);
        return (s == 4'd1) || (s == 4'd2) || (s == 4'd4) || (s == 4'd8);
    endfunction

    function automatic logic [15:0] resp_code(input logic [63:0] cmd);
        return cmd[15:0] + 16'd1;
    endfunction

    function automatic logic [31:0] cap_reset(input int unsigned pl_log2);
        logic [31:0] c;
        c = 32'd0;
        c[4:0] = 5'(pl_log2);
        c[CAP_IRQ_BIT] = 1'b0;
        c[CAP_BG_BIT]  = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int unsigned AW    = 12,
    parameter int unsigned TOTAL = 2080
) (
    input  logic          valid,
    input  logic          write,
    input  logic [AW-1:0] addr,
    input  logic [3:0]    size,
    output acc_t          acc,
    output logic          wr_below,
    output logic          wr_cap,
    output logic          wr_ctrl,
    output logic          wr_cmd,
    output logic          wr_pl
);
    logic [AW:0]   end_a;
    logic [AW-1:0] misal;
    logic          wr_ok;

    always_comb begin
        end_a     = {1'b0, addr} + (AW+1)'(size);
        misal     = addr & AW'(size - 4'd1);
        acc.valid = valid;
        acc.write = write;
        acc.size  = size;
        acc.legal = size_ok(size) && (misal == '0) && (end_a <= (AW+1)'(TOTAL));
        acc.below = addr < AW'(REG_BYTES);
        wr_ok     = valid && write && acc.legal;
        wr_below  = wr_ok && acc.below;
        wr_pl     = wr_ok && !acc.below;
        wr_cap    = wr_below && (size == 4'd4) && (addr == AW'(OFF_CAP));
        wr_ctrl   = wr_below && (size == 4'd4) && (addr == AW'(OFF_CTRL));
        wr_cmd    = wr_below && (size == 4'd8) && (addr == AW'(OFF_CMD));
    end
endmodule

// File: rtl/mbx_payload.sv
module mbx_payload #(
    parameter int unsigned PL_LOG2 = 11
) (
    input  logic               clk,
    input  logic               we,
    input  logic [PL_LOG2-1:0] widx,
    input  logic [3:0]         wsize,
    input  logic [63:0]        wdata,
    input  logic [PL_LOG2-1:0] ridx,
    output logic [63:0]        rdata
);
    localparam int unsigned PL_BYTES = 1 << PL_LOG2;

    logic [7:0] mem [PL_BYTES];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int j = 0; j < 8; j++) begin
                if (j < int'(wsize)) mem[widx + PL_LOG2'(j)] <= wdata[8*j +: 8];
            end
        end
    end

    always_comb begin
        for (int j = 0; j < 8; j++) rdata[8*j +: 8] = mem[ridx + PL_LOG2'(j)];
    end
endmodule

// File: rtl/mbx_responder.sv
module mbx_responder
    import mbx_pkg::*;
#(
    parameter int unsigned LATENCY = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [63:0] cmd_in,
    output logic        busy,
    output logic        fin,
    output logic [15:0] rc
);
    localparam int unsigned CW = $clog2(LATENCY + 1);

    logic [CW-1:0] cnt;
    logic [63:0]   cmd_lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cnt     <= '0;
            cmd_lat <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            cnt     <= CW'(LATENCY - 1);
            cmd_lat <= cmd_in;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign fin = busy && (cnt == '0);
    assign rc  = resp_code(cmd_lat);

    // R9
    fin_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
        fin |=> !busy);
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile
    import mbx_pkg::*;
#(
    parameter int unsigned AW      = 12,
    parameter int unsigned PL_LOG2 = 11,
    parameter int unsigned LATENCY = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [3:0]    req_size,
    input  logic [63:0]   req_wdata,
    output logic          rsp_valid,
    output logic [63:0]   rsp_rdata,
    output logic          rsp_err,
    output logic          cmd_busy,
    output logic          cmd_done
);
    localparam int unsigned PL_BYTES = 1 << PL_LOG2;
    localparam int unsigned TOTAL    = REG_BYTES + PL_BYTES;
    localparam logic [31:0] CAP_INIT = cap_reset(PL_LOG2);

    acc_t        acc;
    logic        wr_below, wr_cap, wr_ctrl, wr_cmd, wr_pl;
    logic [31:0] cap_q, ctrl_q, ctrl_d;
    logic [63:0] cmd_q, sts_q;
    logic [63:0] pl_rdata, rd_data;
    logic [PL_LOG2-1:0] pl_idx;
    logic [8*REG_BYTES-1:0] img;
    logic        start, fin;
    logic [15:0] rc;

    mbx_decode #(.AW(AW), .TOTAL(TOTAL)) dec_i (
        .valid(req_valid), .write(req_write), .addr(req_addr), .size(req_size),
        .acc(acc), .wr_below(wr_below), .wr_cap(wr_cap), .wr_ctrl(wr_ctrl),
        .wr_cmd(wr_cmd), .wr_pl(wr_pl)
    );

    assign pl_idx = PL_LOG2'(req_addr - AW'(REG_BYTES));

    mbx_payload #(.PL_LOG2(PL_LOG2)) pl_i (
        .clk(clk), .we(wr_pl), .widx(pl_idx), .wsize(req_size),
        .wdata(req_wdata), .ridx(pl_idx), .rdata(pl_rdata)
    );

    mbx_responder #(.LATENCY(LATENCY)) rsp_i (
        .clk(clk), .rst(rst), .start(start), .cmd_in(cmd_q),
        .busy(cmd_busy), .fin(fin), .rc(rc)
    );

    // Register image, byte 0 at bit 0; background status is constant zero.
    always_comb begin
        img = '0;
        img[8*OFF_CAP  +: 32] = cap_q;
        img[8*OFF_CTRL +: 32] = ctrl_q;
        img[8*OFF_CMD  +: 64] = cmd_q;
        img[8*16       +: 64] = sts_q;
    end

    always_comb begin
        rd_data = '0;
        for (int j = 0; j < 8; j++) begin
            if (j < int'(req_size)) begin
                rd_data[8*j +: 8] = acc.below
                    ? img[8*((int'(req_addr[REG_AW-1:0]) + j) % REG_BYTES) +: 8]
                    : pl_rdata[8*j +: 8];
            end
        end
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d = req_wdata[31:0];
            if (cmd_busy) ctrl_d[CTRL_DB_BIT] = 1'b1;
        end
        if (fin) ctrl_d[CTRL_DB_BIT] = 1'b0;
        start = wr_below && !cmd_busy && ctrl_d[CTRL_DB_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q     <= CAP_INIT;
            ctrl_q    <= '0;
            cmd_q     <= '0;
            sts_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
            cmd_done  <= 1'b0;
        end else begin
            rsp_valid <= acc.valid;
            rsp_err   <= acc.valid && !acc.legal;
            rsp_rdata <= (acc.valid && !acc.write && acc.legal) ? rd_data : '0;
            cmd_done  <= fin;
            ctrl_q    <= ctrl_d;
            if (wr_cap) cap_q <= req_wdata[31:0];
            if (wr_cmd) cmd_q <= req_wdata;
            if (fin)    sts_q <= {48'd0, rc};
        end
    end

    // R1
    err_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));
    // R10
    db_held_busy_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_busy |-> ctrl_q[CTRL_DB_BIT]);
    // R9
    db_clear_done_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_done |-> !ctrl_q[CTRL_DB_BIT]);
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_done |=> !cmd_done);
    // R9
    sts_only_done_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sts_q) |-> cmd_done);
endmodule

// File: tb/mbx_regfile_tb.sv
module mbx_regfile_tb_top;
    localparam int unsigned AW      = 12;
    localparam int unsigned PL_LOG2 = 11;
    localparam int unsigned LAT     = 8;
    localparam int unsigned TOTAL   = 32 + (1 << PL_LOG2);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr  = '0;
    logic [3:0]    req_size  = 4'd0;
    logic [63:0]   req_wdata = '0;
    logic          rsp_valid, rsp_err, cmd_busy, cmd_done;
    logic [63:0]   rsp_rdata;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int done_seen = 0;
    int done_cyc  = 0;
    logic [7:0] mdl [TOTAL];

    mbx_regfile #(.AW(AW), .PL_LOG2(PL_LOG2), .LATENCY(LAT)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .cmd_busy(cmd_busy), .cmd_done(cmd_done)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (!rst && cmd_done) begin done_seen++; done_cyc = cyc; end

    function automatic bit legal(int unsigned a, int unsigned s);
        return (s == 1 || s == 2 || s == 4 || s == 8) && (a % s == 0) && (a + s <= TOTAL);
    endfunction

    function automatic void mwrite(int unsigned a, int unsigned s, logic [63:0] d);
        if (!legal(a, s)) return;
        if (a >= 32 || (s == 4 && (a == 0 || a == 4)) || (s == 8 && a == 8))
            for (int j = 0; j < int'(s); j++) mdl[a + j] = d[8*j +: 8];
    endfunction

    function automatic logic [63:0] mread(int unsigned a, int unsigned s);
        logic [63:0] r = '0;
        if (!legal(a, s)) return r;
        for (int j = 0; j < int'(s); j++) r[8*j +: 8] = mdl[a + j];
        return r;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input bit w, input int unsigned a, input int unsigned s,
                       input logic [63:0] d, output logic [63:0] rd, output logic er);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = AW'(a);
        req_size = 4'(s); req_wdata = d;
        @(negedge clk);
        rd = rsp_rdata; er = rsp_err;
        req_valid = 1'b0;
        checks++;
        if (rsp_valid !== 1'b1) begin
            fails++;
            $display("FAIL R1 rsp_valid actual=%b expected=1", rsp_valid);
        end
    endtask

    task automatic wr(string req, int unsigned a, int unsigned s, logic [63:0] d);
        logic [63:0] rd; logic er;
        acc(1'b1, a, s, d, rd, er);
        mwrite(a, s, d);
        chk(req, {63'd0, er}, {63'd0, !legal(a, s)});
    endtask

    task automatic rdchk(string req, int unsigned a, int unsigned s);
        logic [63:0] rd; logic er;
        acc(1'b0, a, s, 64'd0, rd, er);
        chk(req, rd, mread(a, s));
        chk(req, {63'd0, er}, {63'd0, !legal(a, s)});
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    task automatic run_cmd(logic [63:0] cmd, logic [31:0] ctrl_val);
        int c_start, prev;
        logic [63:0] rd; logic er;
        wr("R8 cmd write", 8, 8, cmd);
        prev = done_seen;
        wr("R8 doorbell", 4, 4, ctrl_val);
        c_start = cyc;
        chk("R8 busy after doorbell", {63'd0, cmd_busy}, 64'd1);
        // R10: try to clear doorbell, retrigger, and rewrite the command
        acc(1'b1, 4, 4, 64'd0, rd, er);
        acc(1'b0, 4, 4, 64'd0, rd, er);
        chk("R10 doorbell held", {63'd0, rd[0]}, 64'd1);
        acc(1'b1, 4, 4, {32'd0, ctrl_val}, rd, er);
        acc(1'b1, 8, 8, ~cmd, rd, er);
        mwrite(8, 8, ~cmd);
        while (done_seen == prev) @(negedge clk);
        chk("R9 completion cycle", 64'(done_cyc), 64'(c_start + int'(LAT)));
        @(negedge clk);
        chk("R9 done one cycle", {63'd0, cmd_done}, 64'd0);
        chk("R9 busy low", {63'd0, cmd_busy}, 64'd0);
        repeat (LAT + 2) @(negedge clk);
        chk("R10 single done", 64'(done_seen - prev), 64'd1);
        for (int j = 0; j < 8; j++) mdl[16 + j] = 8'd0;
        mdl[16] = 8'(cmd[15:0] + 16'd1);
        mdl[17] = 8'((cmd[15:0] + 16'd1) >> 8);
        for (int j = 0; j < 4; j++) mdl[4 + j] = ctrl_val[8*j +: 8];
        mdl[4][0] = 1'b0;
        rdchk("R9 status rc", 16, 8);
        rdchk("R9 doorbell cleared", 4, 4);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [63:0] rd; logic er;
        void'($urandom(32'd20240611));
        for (int i = 0; i < int'(TOTAL); i++) mdl[i] = 8'd0;
        mdl[0] = 8'(PL_LOG2);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R7 busy reset", {63'd0, cmd_busy}, 64'd0);
        chk("R7 done reset", {63'd0, cmd_done}, 64'd0);
        acc(1'b0, 0, 4, 64'd0, rd, er);
        chk("R7 capability", rd, 64'h0000_000B);
        rdchk("R7 ctrl zero", 4, 4);
        rdchk("R7 cmd zero", 8, 8);
        rdchk("R7 status zero", 16, 8);
        rdchk("R4 bg status zero", 24, 8);
        rdchk("R2 cap+ctrl 8-byte", 0, 8);
        rdchk("R2 cap byte", 0, 1);

        // fill payload with a known pattern
        for (int i = 0; i < (1 << PL_LOG2) / 8; i++)
            wr("R3 fill", 32 + 8*i, 8, {8'(i), 8'hA5, 8'(i * 3), 8'h5A, 32'(i * 32'h01010101)});

        // R1 illegal cases
        acc(1'b0, 32, 3, 64'd0, rd, er);
        chk("R1 size3 err", {63'd0, er}, 64'd1);
        chk("R1 size3 data", rd, 64'd0);
        acc(1'b0, 34, 4, 64'd0, rd, er);
        chk("R1 misaligned err", {63'd0, er}, 64'd1);
        chk("R1 misaligned data", rd, 64'd0);
        rdchk("R1 out of range", TOTAL, 1);
        wr("R1 misaligned write", 36, 8, 64'hDEAD_BEEF_DEAD_BEEF);
        rdchk("R1 misaligned write no effect", 32, 8);
        rdchk("R1 misaligned write no effect hi", 40, 8);

        // R5 / R6 filtering
        wr("R5 4B at cmd", 8, 4, 64'h1234_5678);
        rdchk("R5 cmd unchanged", 8, 8);
        wr("R5 4B at status", 16, 4, 64'h1111_2222);
        rdchk("R5 status unchanged", 16, 8);
        wr("R6 8B at status", 16, 8, 64'hFFFF_FFFF_FFFF_FFFF);
        rdchk("R6 status unchanged", 16, 8);
        wr("R6 8B at bg", 24, 8, 64'hFFFF_FFFF_FFFF_FFFF);
        rdchk("R6 bg zero", 24, 8);
        wr("R6 8B at cap", 0, 8, 64'hFFFF_FFFF_FFFF_FFFF);
        rdchk("R6 cap unchanged", 0, 4);
        wr("R6 2B doorbell", 4, 2, 64'd1);
        wr("R6 1B doorbell", 4, 1, 64'd1);
        rdchk("R6 ctrl unchanged", 4, 4);
        @(negedge clk);
        chk("R6 no start", {63'd0, cmd_busy}, 64'd0);
        wr("R5 cap write", 0, 4, 64'h0000_0C0B);
        rdchk("R5 cap stored", 0, 4);
        wr("R3 last byte", TOTAL - 1, 1, 64'h77);
        rdchk("R3 last byte rd", TOTAL - 1, 1);
        rdchk("R2 last word", TOTAL - 8, 8);

        // commands
        run_cmd(64'h1122_3344_5566_7788, 32'h0000_0001);
        run_cmd(64'h0000_0000_0000_FFFF, 32'h8000_0001);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            int unsigned sz, a, pick;
            logic [63:0] d;
            pick = $urandom % 16;
            case ($urandom % 5)
                0: sz = 1; 1: sz = 2; 2: sz = 4; 3: sz = 8;
                default: sz = (pick == 0) ? 3 : 8;
            endcase
            if (pick < 4) a = ($urandom % (32 / ((sz == 3) ? 1 : sz))) * ((sz == 3) ? 1 : sz);
            else          a = ($urandom % (TOTAL / ((sz == 3) ? 1 : sz))) * ((sz == 3) ? 1 : sz);
            if (pick == 15) a = a + 1;
            d = {$urandom, $urandom};
            if (a == 4 && sz == 4) d[0] = 1'b0;
            if ($urandom % 2) wr("R3 random write", a, sz, d);
            else              rdchk("R2 random read", a, sz);
        end
        rdchk("R4 final status", 16, 8);
        finish_run();
    end
endmodule